// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block is the column-burst engine of a synchronous DRAM device model. Each clock it samples a command code and a starting column. A read or write command starts a burst that emits one column address per clock. The order of those addresses is set by a programmed burst length and burst type. A terminate command stops the burst. A fresh read or write replaces it on any cycle. Write beats drive a write strobe with per-byte enables taken from two mask pins. Read beats pass through a latency pipe, so the read-valid strobe and the column of the returning word appear two or three clocks after the column was issued.

The settings pins (length, full-page select, interleave select, latency select) are captured with each read or write command. Changing them during a burst does not affect that burst. An illegal pairing is flagged on a plain error output, and the burst runs as eight beats: a full-page length with interleaved order. No interface has back-pressure. Every command is accepted on the edge that samples it, and the outputs are plain strobes with no ready input.

Top module: `sdr_burst_seq`

## Requirements
- R1: While reset is asserted and after it is released, with no command, `col_valid`, `wr_en`, `wr_be` and `rd_valid` are all 0.
- R2: A read or write with interleave off and full-page off starts a burst of 2^`cfg_len_log2` beats (codes 0..3 give 1, 2, 4, 8). Beat i is shown on `col_addr` with `col_valid`=1 in the clock period after edge k+i, where k is the command edge. The column keeps the start's upper bits and sets the low log2(length) bits to (start low bits + i) mod length. `col_valid` is 0 after the last beat.
- R3: With `cfg_interleave`=1, beat i sets the low log2(length) bits to the start's low bits XOR i.
- R4: With `cfg_full_page`=1 and interleave off, beat i is (start + i) mod 512. The burst never ends on its own.
- R5: A read beat shown after edge j gives `rd_valid`=1 and `rd_col` equal to that column after edge j+2 when `cfg_cas3`=0 at the command, and after edge j+3 when it is 1. `rd_valid` is 0 otherwise.
- R6: A terminate command (`cmd_op`=3) makes `col_valid` and `wr_en` 0 from the next edge. Read beats already issued still come out of the latency pipe.
- R7: A read (`cmd_op`=1) or write (`cmd_op`=2) sampled during a burst drops the old burst. Beat 0 of the new burst is at the command's column after that edge.
- R8: During write beats `wr_en`=1, `wr_be[1]`=!`mask_hi` and `wr_be[0]`=!`mask_lo`, with masks applied in the same cycle. `wr_be` is 0 whenever `wr_en` is 0.
- R9: `cfg_err` is 1 exactly when full-page and interleave are both selected. A burst started with that setting runs 8 interleaved beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_op | input | 2 | 0 idle, 1 read, 2 write, 3 terminate |
| cmd_col | input | 9 | Starting column of a read or write |
| cfg_len_log2 | input | 2 | Burst length code, length 2^code |
| cfg_full_page | input | 1 | Full-page burst select |
| cfg_interleave | input | 1 | 1 selects interleaved order |
| cfg_cas3 | input | 1 | Read latency 3 when 1, else 2 |
| mask_hi | input | 1 | Blocks the upper byte of the current write beat |
| mask_lo | input | 1 | Blocks the lower byte of the current write beat |
| col_valid | output | 1 | A beat is being issued |
| col_addr | output | 9 | Column of the current beat |
| wr_en | output | 1 | Current beat is a write |
| wr_be | output | 2 | Byte enables, bit 1 upper |
| rd_valid | output | 1 | Read word of an issued column emerges |
| rd_col | output | 9 | Column of the emerging read word |
| cfg_err | output | 1 | Illegal setting flag |

## Verification
Properties check on every cycle the reset state and the next-edge response to each command code. They check that a read or write starts at the sampled column, that a terminate silences issue, and that byte enables only appear under the write strobe. They also check that every read-valid pulse is preceded, two or three edges earlier, by a read beat. The exact address orders only show in the directed scenarios: sequential wrap inside the aligned block, XOR order, and the full-page roll past column 511. The same holds for the exact latency per setting, pipe draining after a terminate, and the fallback length.

// File: rtl/sdr_burst_pkg.sv
package sdr_burst_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_TERM  = 2'd3
  } burst_op_e;
endpackage

// File: rtl/sdr_burst_cfg.sv
module sdr_burst_cfg (
  input  logic [1:0] len_log2,
  input  logic       full_page,
  input  logic       interleave,
  output logic [1:0] eff_len_log2,
  output logic       eff_full,
  output logic       err
);
  // Full-page walks only in sequential order; otherwise fall back to 8 beats.
  always_comb begin
    err          = full_page & interleave;
    eff_full     = full_page & ~interleave;
    eff_len_log2 = err ? 2'd3 : len_log2;
  end
endmodule

// File: rtl/sdr_burst_addr.sv
module sdr_burst_addr #(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] start,
  input  logic [COL_W-1:0] beat,
  input  logic [1:0]       len_log2,
  input  logic             full,
  input  logic             interleave,
  output logic [COL_W-1:0] col
);
  localparam logic [COL_W-1:0] ONE = COL_W'(1);
  logic [COL_W-1:0] low_mask;
  logic [COL_W-1:0] moved;

  always_comb begin
    low_mask = full ? '1 : ((ONE << len_log2) - ONE);
    moved    = interleave ? (start ^ beat) : (start + beat);
    col      = (start & ~low_mask) | (moved & low_mask);
  end
endmodule

// File: rtl/sdr_burst_rdpipe.sv
module sdr_burst_rdpipe #(
  parameter int COL_W  = 9,
  parameter int MAX_CL = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [COL_W-1:0] in_col,
  input  logic             long_lat,
  output logic             out_valid,
  output logic [COL_W-1:0] out_col
);
  logic             v_q [MAX_CL];
  logic [COL_W-1:0] c_q [MAX_CL];

  for (genvar g = 0; g < MAX_CL; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_q[0] <= 1'b0;
          c_q[0] <= '0;
        end else begin
          v_q[0] <= in_valid;
          c_q[0] <= in_col;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_q[g] <= 1'b0;
          c_q[g] <= '0;
        end else begin
          v_q[g] <= v_q[g-1];
          c_q[g] <= c_q[g-1];
        end
      end
    end
  end

  assign out_valid = long_lat ? v_q[MAX_CL-1] : v_q[MAX_CL-2];
  assign out_col   = long_lat ? c_q[MAX_CL-1] : c_q[MAX_CL-2];
endmodule

// File: rtl/sdr_burst_seq.sv
module sdr_burst_seq
  import sdr_burst_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int MAX_CL = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cmd_op,
  input  logic [COL_W-1:0] cmd_col,
  input  logic [1:0]       cfg_len_log2,
  input  logic             cfg_full_page,
  input  logic             cfg_interleave,
  input  logic             cfg_cas3,
  input  logic             mask_hi,
  input  logic             mask_lo,
  output logic             col_valid,
  output logic [COL_W-1:0] col_addr,
  output logic             wr_en,
  output logic [1:0]       wr_be,
  output logic             rd_valid,
  output logic [COL_W-1:0] rd_col,
  output logic             cfg_err
);
  localparam logic [COL_W-1:0] ONE = COL_W'(1);

  logic [1:0]       eff_len;
  logic             eff_full;
  logic             active_q, write_q, full_q, ilv_q, cas3_q;
  logic [1:0]       len_q;
  logic [COL_W-1:0] start_q, beat_q, last_beat;
  logic             starts, stops, at_last;
  burst_op_e        op;

  assign op = burst_op_e'(cmd_op);

  sdr_burst_cfg u_cfg (
    .len_log2     (cfg_len_log2),
    .full_page    (cfg_full_page),
    .interleave   (cfg_interleave),
    .eff_len_log2 (eff_len),
    .eff_full     (eff_full),
    .err          (cfg_err)
  );

  assign starts    = (op == OP_READ) || (op == OP_WRITE);
  assign stops     = (op == OP_TERM);
  assign last_beat = (ONE << len_q) - ONE;
  assign at_last   = !full_q && (beat_q == last_beat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      write_q  <= 1'b0;
      full_q   <= 1'b0;
      ilv_q    <= 1'b0;
      cas3_q   <= 1'b0;
      len_q    <= '0;
      start_q  <= '0;
      beat_q   <= '0;
    end else if (starts) begin
      active_q <= 1'b1;
      write_q  <= (op == OP_WRITE);
      full_q   <= eff_full;
      ilv_q    <= cfg_interleave;
      len_q    <= eff_len;
      start_q  <= cmd_col;
      beat_q   <= '0;
      if (op == OP_READ) cas3_q <= cfg_cas3;
    end else if (stops) begin
      active_q <= 1'b0;
    end else if (active_q) begin
      if (at_last) active_q <= 1'b0;
      else         beat_q   <= beat_q + ONE;
    end
  end

  sdr_burst_addr #(.COL_W(COL_W)) u_addr (
    .start      (start_q),
    .beat       (beat_q),
    .len_log2   (len_q),
    .full       (full_q),
    .interleave (ilv_q),
    .col        (col_addr)
  );

  assign col_valid = active_q;
  assign wr_en     = active_q & write_q;
  assign wr_be     = {wr_en & ~mask_hi, wr_en & ~mask_lo};

  sdr_burst_rdpipe #(.COL_W(COL_W), .MAX_CL(MAX_CL)) u_rdpipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (active_q & ~write_q),
    .in_col    (col_addr),
    .long_lat  (cas3_q),
    .out_valid (rd_valid),
    .out_col   (rd_col)
  );
endmodule

// File: rtl/sdr_burst_seq_chk.sv
module sdr_burst_seq_chk #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       cmd_op,
  input logic [COL_W-1:0] cmd_col,
  input logic             col_valid,
  input logic [COL_W-1:0] col_addr,
  input logic             wr_en,
  input logic [1:0]       wr_be,
  input logic             rd_valid
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!col_valid && !wr_en && !rd_valid));

  assert_read_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 2'd1) |=> (col_valid && !wr_en && col_addr == $past(cmd_col)));

  assert_write_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 2'd2) |=> (wr_en && col_addr == $past(cmd_col)));

  assert_term_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 2'd3) |=> (!col_valid && !wr_en));

  assert_be_under_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_be != 2'b00) |-> wr_en);

  assert_rd_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(col_valid && !wr_en, 2) || $past(col_valid && !wr_en, 3)));
endmodule

bind sdr_burst_seq sdr_burst_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_op    (cmd_op),
  .cmd_col   (cmd_col),
  .col_valid (col_valid),
  .col_addr  (col_addr),
  .wr_en     (wr_en),
  .wr_be     (wr_be),
  .rd_valid  (rd_valid)
);

// File: tb/sdr_burst_seq_tb.sv
module sdr_burst_seq_tb;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [8:0] cmd_col = '0;
  logic [1:0] cfg_len_log2 = 2'd2;
  logic       cfg_full_page = 1'b0, cfg_interleave = 1'b0, cfg_cas3 = 1'b0;
  logic       mask_hi = 1'b0, mask_lo = 1'b0;
  logic       col_valid, wr_en, rd_valid, cfg_err;
  logic [8:0] col_addr, rd_col;
  logic [1:0] wr_be;
  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  sdr_burst_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_col(cmd_col),
    .cfg_len_log2(cfg_len_log2), .cfg_full_page(cfg_full_page),
    .cfg_interleave(cfg_interleave), .cfg_cas3(cfg_cas3),
    .mask_hi(mask_hi), .mask_lo(mask_lo), .col_valid(col_valid),
    .col_addr(col_addr), .wr_en(wr_en), .wr_be(wr_be),
    .rd_valid(rd_valid), .rd_col(rd_col), .cfg_err(cfg_err)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_col(int s, int i, int lg, bit full, bit ilv);
    int bl, base, off;
    if (full) return (s + i) % 512;
    bl   = 1 << lg;
    base = s - (s % bl);
    off  = ilv ? ((s % bl) ^ (i % bl)) : (((s % bl) + i) % bl);
    return base + off;
  endfunction

  task automatic set_cfg(int lg, bit full, bit ilv, bit cas3);
    cfg_len_log2 = 2'(lg); cfg_full_page = full; cfg_interleave = ilv; cfg_cas3 = cas3;
  endtask

  // Issue a write burst and check its column order and length.
  task automatic t_write_order(string req, int col, int lg, bit full, bit ilv, int nbeats);
    @(negedge clk); cmd_op = 2'd2; cmd_col = 9'(col);
    @(negedge clk); cmd_op = 2'd0;
    set_cfg(0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < nbeats; i++) begin
      chk(req, "col_valid", int'(col_valid), 1);
      chk(req, "col_addr", int'(col_addr), exp_col(col, i, lg, full, ilv));
      @(negedge clk);
    end
    chk(req, "col_valid after burst", int'(col_valid), 0);
  endtask

  task automatic t_reset();
    chk("R1", "col_valid in reset", int'(col_valid), 0);
    chk("R1", "rd_valid in reset", int'(rd_valid), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "col_valid idle", int'(col_valid), 0);
    chk("R1", "wr_en idle", int'(wr_en), 0);
    chk("R1", "wr_be idle", int'(wr_be), 0);
  endtask

  task automatic t_read_latency(bit cas3, int col, int lg);
    int cl = cas3 ? 3 : 2;
    int bl = 1 << lg;
    set_cfg(lg, 1'b0, 1'b0, cas3);
    @(negedge clk); cmd_op = 2'd1; cmd_col = 9'(col);
    @(negedge clk); cmd_op = 2'd0;
    for (int j = 0; j < bl + cl + 2; j++) begin
      chk("R5", "rd_valid", int'(rd_valid), int'(j >= cl && j < cl + bl));
      if (j >= cl && j < cl + bl)
        chk("R5", "rd_col", int'(rd_col), exp_col(col, j - cl, lg, 1'b0, 1'b0));
      @(negedge clk);
    end
  endtask

  task automatic t_term_read();
    set_cfg(3, 1'b0, 1'b0, 1'b1);
    @(negedge clk); cmd_op = 2'd1; cmd_col = 9'd3;
    @(negedge clk); cmd_op = 2'd0;
    for (int j = 0; j < 8; j++) begin
      chk("R6", "col_valid", int'(col_valid), int'(j < 2));
      chk("R6", "rd_valid drain", int'(rd_valid), int'(j == 3 || j == 4));
      if (j == 3 || j == 4) chk("R6", "rd_col drain", int'(rd_col), j);
      if (j == 1) cmd_op = 2'd3;
      if (j == 2) cmd_op = 2'd0;
      @(negedge clk);
    end
  endtask

  task automatic t_interrupt();
    set_cfg(3, 1'b0, 1'b0, 1'b0);
    @(negedge clk); cmd_op = 2'd2; cmd_col = 9'd0;
    @(negedge clk); cmd_op = 2'd0;
    for (int j = 0; j < 14; j++) begin
      if (j < 3) begin
        chk("R7", "old write beat", int'(col_addr), j);
        chk("R7", "old wr_en", int'(wr_en), 1);
      end else begin
        chk("R7", "new col_valid", int'(col_valid), int'(j < 11));
        chk("R7", "new wr_en", int'(wr_en), 0);
        if (j < 11) chk("R7", "new col", int'(col_addr), exp_col(20, j - 3, 3, 1'b0, 1'b0));
        chk("R7", "new rd_valid", int'(rd_valid), int'(j >= 5 && j < 13));
        if (j >= 5 && j < 13) chk("R7", "new rd_col", int'(rd_col), exp_col(20, j - 5, 3, 1'b0, 1'b0));
      end
      if (j == 2) begin cmd_op = 2'd1; cmd_col = 9'd20; end
      if (j == 3) cmd_op = 2'd0;
      @(negedge clk);
    end
  endtask

  task automatic t_masks();
    set_cfg(2, 1'b0, 1'b0, 1'b0);
    @(negedge clk); cmd_op = 2'd2; cmd_col = 9'd8;
    @(negedge clk); cmd_op = 2'd0;
    for (int i = 0; i < 4; i++) begin
      mask_hi = i[0]; mask_lo = i[1];
      #1;
      chk("R8", "wr_en", int'(wr_en), 1);
      chk("R8", "wr_be", int'(wr_be), int'({~i[0], ~i[1]}));
      @(negedge clk);
    end
    mask_hi = 1'b0; mask_lo = 1'b0; #1;
    chk("R8", "wr_be idle", int'(wr_be), 0);
  endtask

  task automatic t_full_page();
    set_cfg(0, 1'b1, 1'b0, 1'b0);
    @(negedge clk); cmd_op = 2'd2; cmd_col = 9'd508;
    @(negedge clk); cmd_op = 2'd0;
    for (int i = 0; i < 520; i++) begin
      chk("R4", "full page col", int'(col_addr), (508 + i) % 512);
      chk("R4", "full page valid", int'(col_valid), 1);
      if (i == 519) cmd_op = 2'd3;
      @(negedge clk);
    end
    cmd_op = 2'd0;
    chk("R6", "terminated full page", int'(col_valid), 0);
  endtask

  task automatic t_fallback();
    set_cfg(0, 1'b1, 1'b1, 1'b0);
    #1;
    chk("R9", "cfg_err on", int'(cfg_err), 1);
    t_write_order("R9", 10, 3, 1'b0, 1'b1, 8);
    #1;
    chk("R9", "cfg_err off", int'(cfg_err), 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    set_cfg(2, 1'b0, 1'b0, 1'b0); t_write_order("R2", 6, 2, 1'b0, 1'b0, 4);
    set_cfg(3, 1'b0, 1'b0, 1'b0); t_write_order("R2", 13, 3, 1'b0, 1'b0, 8);
    set_cfg(0, 1'b0, 1'b0, 1'b0); t_write_order("R2", 7, 0, 1'b0, 1'b0, 1);
    set_cfg(1, 1'b0, 1'b0, 1'b0); t_write_order("R2", 33, 1, 1'b0, 1'b0, 2);
    set_cfg(3, 1'b0, 1'b1, 1'b0); t_write_order("R3", 5, 3, 1'b0, 1'b1, 8);
    set_cfg(2, 1'b0, 1'b1, 1'b0); t_write_order("R3", 98, 2, 1'b0, 1'b1, 4);
    t_read_latency(1'b0, 6, 2);
    t_read_latency(1'b1, 17, 2);
    t_term_read();
    t_interrupt();
    t_masks();
    t_full_page();
    t_fallback();
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule